// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is a synchronous, device-side model of the command register of a byte-wide NOR flash. It watches single-cycle write strobes on a write port, recognises multi-write command sequences that begin with a two-write unlock prefix, and turns them into byte-program, chip-erase, boot-lock and identification-mode actions on a small parameterised cell array. Programming can only clear bits, since each cell becomes the old value ANDed with the new byte. Erase restores every cell to FFh with a walk of one cell per cycle.

A boot region at the bottom or at the top of the address space (chosen by a parameter) can be locked. After that, programs to it are dropped and erase skips it, unless the override input is high. Busy timing belongs to a companion block: each accepted operation raises a one-cycle `op_start` with an operation code, and this block stays busy until that companion answers on `op_done` and any erase walk has finished. A registered read port returns cell contents, or identification bytes and the lock status while identification mode is active.

Top module: `flash_cmd_unit`

## Requirements
- R1: During and right after synchronous active-low reset, `busy` and `op_start` are 0, the boot lock is clear and identification mode is off.
- R2: The unlock addresses are 5555h and 2AAAh reduced to their low min(ADDR_W,15) bits (555h and 2AAh at the default ADDR_W=11). AAh to the first unlock address, 55h to the second, A0h to the first, and then a data byte to any address form a program. `op_start` pulses for one cycle after the last write, with `op_kind`=01, and the addressed cell takes its new value on the following edge.
- R3: A program stores old AND data, so no bit ever goes from 0 to 1 by programming.
- R4: A chip erase is the prefix, 80h to the first unlock address, the prefix again, then 10h to the first unlock address. It gives `op_kind`=10 and leaves every unprotected cell at FFh.
- R5: The same six-write form with 40h as the final byte gives `op_kind`=11 and sets the boot lock. The lock stays set until reset.
- R6: The prefix followed by 90h to the first unlock address enters identification mode. There, reads return 1Fh at address 0, the device code at address 1 (23h bottom boot, 27h top boot), 0000000 followed by the lock bit in bit 0 at the lock-status address (F3002h for top boot and 00002h for bottom boot, reduced to ADDR_W bits), and 00h elsewhere.
- R7: Identification mode is left either by one F0h write to any address while the sequence decoder is idle, or by the prefix followed by F0h to the first unlock address. Reads then return cell contents again.
- R8: The boot region covers the lowest or highest 2^BOOT_AW addresses. While it is locked and `boot_override` is 0, programs into it leave the cell unchanged and erase leaves it intact.
- R9: With `boot_override` at 1, a locked boot region is programmed and erased like any other cell.
- R10: A write that does not match the next expected cycle of a sequence returns the decoder to idle. Later writes must then restart from the prefix.
- R11: `busy` is 1 from `op_start` until `op_done` has been seen and any erase walk has ended. Writes made while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| boot_override | input | 1 | Lifts boot-region protection while high |
| op_start | output | 1 | One-cycle pulse when an operation is accepted |
| op_kind | output | 2 | Operation code: 01 program, 10 erase, 11 lock |
| op_done | input | 1 | Completion pulse from the timing block |
| busy | output | 1 | Operation in progress; writes ignored |

## Verification
The hardest situation to reach is a full, well-formed command arriving while a previous operation is still pending. The bench gets there by starting a program and holding back `op_done`, then issuing a complete second program sequence, which must leave no trace. Protected-region behaviour needs the lock to be set first through its six-write sequence. After that the bench mixes directed erases and programs with and without the override, followed by random programs whose addresses are biased into the boot region and whose override level is drawn at random. Every read is compared with a model of the array kept in the bench.

// File: rtl/flash_cmd_pkg.sv
// Shared codes for the flash command interpreter: sequence states,
// operation codes and the command byte and unlock address constants.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_LOCK  = 2'b11
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PDATA,
        SQ_EXT3,
        SQ_EXT4,
        SQ_EXT5
    } seq_state_e;

    localparam logic [14:0] ADR_FIRST  = 15'h5555;
    localparam logic [14:0] ADR_SECOND = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_EXT    = 8'h80;
    localparam logic [7:0] CMD_ERASE  = 8'h10;
    localparam logic [7:0] CMD_LOCK   = 8'h40;
    localparam logic [7:0] CMD_ID_IN  = 8'h90;
    localparam logic [7:0] CMD_ID_OUT = 8'hF0;
    localparam logic [7:0] ID_MAKER   = 8'h1F;
    localparam logic [7:0] ID_DEV_BOT = 8'h23;
    localparam logic [7:0] ID_DEV_TOP = 8'h27;

endpackage

// File: rtl/flash_seq_decoder.sv
// Sequence decoder: follows unlock-prefixed write sequences and issues one
// registered command pulse when a program, erase or lock sequence completes.
// It also owns the identification-mode flag.
// Assumes: writes are single-cycle strobes; no write is accepted while busy.
module flash_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              cmd_valid,
    output op_kind_e          cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              id_mode
);
    localparam int CMP_W = (ADDR_W < 15) ? ADDR_W : 15;

    seq_state_e state_q, state_nx;
    logic       id_nx;
    logic       fire;
    op_kind_e   fire_kind;
    logic       acc, at_first, at_second, hit_first, hit_second;

    assign acc        = wr_en && !busy;
    assign at_first   = (wr_addr[CMP_W-1:0] == ADR_FIRST[CMP_W-1:0]);
    assign at_second  = (wr_addr[CMP_W-1:0] == ADR_SECOND[CMP_W-1:0]);
    assign hit_first  = at_first && (wr_data == KEY_FIRST);
    assign hit_second = at_second && (wr_data == KEY_SECOND);

    // Next sequence state, mode flag and command fire decision.
    always_comb begin
        state_nx  = state_q;
        id_nx     = id_mode;
        fire      = 1'b0;
        fire_kind = OP_NONE;
        if (acc) begin
            state_nx = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: begin
                    if (hit_first) state_nx = SQ_UNL1;
                    else if (wr_data == CMD_ID_OUT) id_nx = 1'b0;
                end
                SQ_UNL1: if (hit_second) state_nx = SQ_UNL2;
                SQ_UNL2: begin
                    if (at_first) begin
                        case (wr_data)
                            CMD_PROG:   state_nx = SQ_PDATA;
                            CMD_EXT:    state_nx = SQ_EXT3;
                            CMD_ID_IN:  id_nx = 1'b1;
                            CMD_ID_OUT: id_nx = 1'b0;
                            default:    state_nx = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PDATA: begin
                    fire      = 1'b1;
                    fire_kind = OP_PROG;
                end
                SQ_EXT3: if (hit_first) state_nx = SQ_EXT4;
                SQ_EXT4: if (hit_second) state_nx = SQ_EXT5;
                SQ_EXT5: begin
                    if (at_first && wr_data == CMD_ERASE) begin
                        fire      = 1'b1;
                        fire_kind = OP_ERASE;
                    end else if (at_first && wr_data == CMD_LOCK) begin
                        fire      = 1'b1;
                        fire_kind = OP_LOCK;
                    end
                end
                default: state_nx = SQ_IDLE;
            endcase
        end
    end

    // State, mode and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            id_mode   <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_kind  <= OP_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            state_q   <= state_nx;
            id_mode   <= id_nx;
            cmd_valid <= fire;
            if (fire) begin
                cmd_kind <= fire_kind;
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end

    // R11
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(state_q) && !cmd_valid));

    // R6
    id_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(id_mode));

endmodule

// File: rtl/flash_cell_array.sv
// Cell array with bit-clearing program and a one-cell-per-cycle erase walk.
// A locked boot region is skipped unless the override is high.
// Assumes: program and erase never overlap (the decoder blocks this).
// Cell contents are not reset; they model storage that outlives reset.
module flash_cell_array #(
    parameter int ADDR_W   = 11,
    parameter int BOOT_AW  = 8,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_go,
    input  logic              lock,
    input  logic              override,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              erase_active
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] walk_q;
    logic              guard;

    function automatic logic in_boot(input logic [ADDR_W-1:0] a);
        if (TOP_BOOT) return &a[ADDR_W-1:BOOT_AW];
        else          return ~|a[ADDR_W-1:BOOT_AW];
    endfunction

    assign guard   = lock && !override;
    assign rd_data = mem[rd_addr];

    // Cell updates: program clears bits, erase walk sets cells to FFh.
    always_ff @(posedge clk) begin
        if (prog_en && !(guard && in_boot(prog_addr)))
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        else if (erase_active && !(guard && in_boot(walk_q)))
            mem[walk_q] <= 8'hFF;
    end

    // Erase walk sequencing over every address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_active <= 1'b0;
            walk_q       <= '0;
        end else if (erase_go) begin
            erase_active <= 1'b1;
            walk_q       <= '0;
        end else if (erase_active) begin
            walk_q <= walk_q + 1'b1;
            if (walk_q == LAST) erase_active <= 1'b0;
        end
    end

    // R4
    erase_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_active && walk_q != LAST) |=> erase_active);

endmodule

// File: rtl/flash_cmd_unit.sv
// Top of the flash command interpreter: ties the sequence decoder to the cell
// array, keeps the boot lock and the busy handshake with the external timing
// block, and serves the registered read port (cells or identification data).
// Assumes: op_done is a pulse from the timing block after op_start.
module flash_cmd_unit
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int BOOT_AW  = 8,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              boot_override,
    output logic              op_start,
    output logic [1:0]        op_kind,
    input  logic              op_done,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] ID_LOCK_ADR =
        TOP_BOOT ? ADDR_W'(20'hF3002) : ADDR_W'(20'h00002);
    localparam logic [7:0] DEV_CODE = TOP_BOOT ? ID_DEV_TOP : ID_DEV_BOT;

    logic              cmd_valid, id_mode, erase_active;
    op_kind_e          cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data, cell_rd;
    logic              lock_q, busy_q, done_seen;

    assign busy     = busy_q | cmd_valid;
    assign op_start = cmd_valid;
    assign op_kind  = cmd_kind;

    flash_seq_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .busy      (busy),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .id_mode   (id_mode)
    );

    flash_cell_array #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)) u_arr (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_en      (cmd_valid && cmd_kind == OP_PROG),
        .prog_addr    (cmd_addr),
        .prog_data    (cmd_data),
        .erase_go     (cmd_valid && cmd_kind == OP_ERASE),
        .lock         (lock_q),
        .override     (boot_override),
        .rd_addr      (rd_addr),
        .rd_data      (cell_rd),
        .erase_active (erase_active)
    );

    // Boot lock: set by the lock command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               lock_q <= 1'b0;
        else if (cmd_valid && cmd_kind == OP_LOCK) lock_q <= 1'b1;
    end

    // Busy handshake: hold until completion seen and erase walk ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_seen <= 1'b0;
        end else if (cmd_valid) begin
            busy_q    <= 1'b1;
            done_seen <= 1'b0;
        end else if (busy_q) begin
            if ((done_seen || op_done) && !erase_active) begin
                busy_q    <= 1'b0;
                done_seen <= 1'b0;
            end else if (op_done) begin
                done_seen <= 1'b1;
            end
        end
    end

    // Registered read: identification data in id mode, else cell contents.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_data <= '0;
        else if (!id_mode)   rd_data <= cell_rd;
        else if (rd_addr == '0)          rd_data <= ID_MAKER;
        else if (rd_addr == ADDR_W'(1))  rd_data <= DEV_CODE;
        else if (rd_addr == ID_LOCK_ADR) rd_data <= {7'd0, lock_q};
        else                             rd_data <= 8'h00;
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !op_done && !done_seen) |=> busy);

    // R4
    erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_active |-> busy);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

endmodule

// File: tb/flash_cmd_unit_bench.sv
module flash_cmd_unit_bench;
    localparam int ADDR_W  = 11;
    localparam int BOOT_AW = 8;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] A1 = 11'h555;
    localparam logic [ADDR_W-1:0] A2 = 11'h2AA;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              boot_override = 1'b0;
    logic              op_start;
    logic [1:0]        op_kind;
    logic              op_done = 1'b0;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] ref_mem [DEPTH];
    logic       ref_lock = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_unit #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(1'b0)) u_flash_cmd_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .boot_override(boot_override),
        .op_start(op_start), .op_kind(op_kind), .op_done(op_done), .busy(busy)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic boot_cell(input logic [ADDR_W-1:0] a);
        return a < ADDR_W'(1 << BOOT_AW);
    endfunction

    function automatic logic guarded(input logic [ADDR_W-1:0] a);
        return ref_lock && !boot_override && boot_cell(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic prefix();
        bus_wr(A1, 8'hAA);
        bus_wr(A2, 8'h55);
    endtask

    task automatic finish_op();
        repeat (2) @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        check("R11 busy released", {31'd0, busy}, 32'd0);
    endtask

    task automatic do_prog(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        prefix();
        bus_wr(A1, 8'hA0);
        bus_wr(a, d);
        check({req, " R2 op_start"}, {30'd0, op_start, busy}, {30'd0, 2'b11});
        check({req, " R2 op_kind"}, {30'd0, op_kind}, 32'd1);
        if (!guarded(a)) ref_mem[a] = ref_mem[a] & d;
        finish_op();
    endtask

    task automatic do_ext(input logic [7:0] last);
        prefix();
        bus_wr(A1, 8'h80);
        prefix();
        bus_wr(A1, last);
    endtask

    task automatic do_erase(input string req);
        do_ext(8'h10);
        check({req, " R4 op_start"}, {31'd0, op_start}, 32'd1);
        check({req, " R4 op_kind"}, {30'd0, op_kind}, 32'd2);
        for (int i = 0; i < DEPTH; i++)
            if (!guarded(ADDR_W'(i))) ref_mem[i] = 8'hFF;
        finish_op();
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hXX;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        check("R1 op_start in reset", {31'd0, op_start}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);

        // R4: erase from unknown contents
        do_erase("first erase");
        rd_chk("R4 erased low", 11'h000, 8'hFF);
        rd_chk("R4 erased high", 11'h7FF, 8'hFF);
        rd_chk("R4 erased mid", 11'h3A5, 8'hFF);

        // R2, R3: program and bit-clearing only
        do_prog("R2 prog", 11'h300, 8'h5A);
        rd_chk("R2 programmed value", 11'h300, 8'h5A);
        do_prog("R3 prog", 11'h300, 8'hF0);
        rd_chk("R3 only clears bits", 11'h300, 8'h50);

        // R6, R7: identification mode and both exits
        prefix();
        bus_wr(A1, 8'h90);
        check("R6 id entry no op", {31'd0, op_start}, 32'd0);
        rd_chk("R6 maker code", 11'h000, 8'h1F);
        rd_chk("R6 device code", 11'h001, 8'h23);
        rd_chk("R6 lock status clear (R1)", 11'h002, 8'h00);
        rd_chk("R6 other address", 11'h300, 8'h00);
        bus_wr(11'h123, 8'hF0);
        rd_chk("R7 single-write exit", 11'h300, 8'h50);
        prefix();
        bus_wr(A1, 8'h90);
        rd_chk("R6 re-entry", 11'h000, 8'h1F);
        prefix();
        bus_wr(A1, 8'hF0);
        rd_chk("R7 prefixed exit", 11'h000, 8'hFF);

        // R10: mismatch returns to idle
        bus_wr(A1, 8'hAA);
        bus_wr(A2, 8'h12);
        bus_wr(A2, 8'h55);
        bus_wr(A1, 8'hA0);
        bus_wr(11'h010, 8'h00);
        check("R10 no op after mismatch", {31'd0, op_start}, 32'd0);
        rd_chk("R10 cell untouched", 11'h010, 8'hFF);

        // R11: commands ignored while busy
        prefix();
        bus_wr(A1, 8'hA0);
        bus_wr(11'h020, 8'h0F);
        ref_mem[11'h020] = 8'h0F;
        repeat (20) @(negedge clk);
        check("R11 busy held without done", {31'd0, busy}, 32'd1);
        prefix();
        bus_wr(A1, 8'hA0);
        bus_wr(11'h021, 8'h00);
        check("R11 no start while busy", {31'd0, op_start}, 32'd0);
        finish_op();
        rd_chk("R11 ignored program", 11'h021, 8'hFF);
        rd_chk("R11 first program", 11'h020, 8'h0F);

        // R5: lock the boot region
        do_ext(8'h40);
        check("R5 op_start", {31'd0, op_start}, 32'd1);
        check("R5 op_kind", {30'd0, op_kind}, 32'd3);
        ref_lock = 1'b1;
        finish_op();
        prefix();
        bus_wr(A1, 8'h90);
        rd_chk("R5 lock status set", 11'h002, 8'h01);
        bus_wr(11'h000, 8'hF0);

        // R8: locked region protected
        do_prog("R8 prog locked", 11'h030, 8'h00);
        rd_chk("R8 locked program ignored", 11'h030, 8'hFF);
        do_prog("R8 prog open", 11'h400, 8'h00);
        do_erase("R8 erase");
        rd_chk("R8 boot kept by erase", 11'h020, 8'h0F);
        rd_chk("R8 main erased", 11'h400, 8'hFF);

        // R9: override lifts protection
        boot_override = 1'b1;
        do_prog("R9 prog", 11'h030, 8'h3C);
        rd_chk("R9 override program", 11'h030, 8'h3C);
        do_erase("R9 erase");
        rd_chk("R9 override erase", 11'h020, 8'hFF);
        boot_override = 1'b0;

        // Random programs against the bench model (R3, R8, R9)
        for (int n = 0; n < 60; n++) begin
            logic [ADDR_W-1:0] a;
            logic [7:0] d;
            a = ADDR_W'($urandom);
            if ($urandom % 2 == 0) a = a & ADDR_W'((1 << BOOT_AW) - 1);
            d = 8'($urandom);
            boot_override = 1'($urandom);
            do_prog("R3 random", a, d);
            boot_override = 1'b0;
            rd_chk("R8 R9 random readback", a, ref_mem[a]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule